// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a parameterised chain of boundary cells that sits between the core logic and the device pins. Each cell has two parts. One is a capture/shift stage clocked on the rising edge of the test clock. The other is an update latch that loads from that stage on the falling edge. Because of this split, test data can move through the chain while the pins keep the values of the last update.

The chain has three kinds of cell:
- input cells, one for each input pin;
- output data cells, one for each output pin;
- control cells, one for each group of output pins. A control cell decides the output enable of every data pin in its group.

A separate test controller decodes the instruction into a 3-bit mode. It also supplies the capture, shift and update strobes for the data-register path. The serial output of the chain goes to an outside multiplexer that selects the test data output.

Top module: `bsr_chain`

## Requirements
- R1: A synchronous active-low reset clears every capture/shift stage on the rising edge and every update latch on the falling edge. After reset, `chain_tdo` is 0, and in mode 2 all `pin_out` and `pin_oe` bits are 0.
- R2: The mode codes are: 0 functional, 1 sample/preload, 2 external test, 3 internal test, 4 clamp, 5 high impedance. Codes 6 and 7 behave as functional. In functional mode, `pin_out`=`core_out`, `pin_in` reaches `core_in`, and every pin in group g has `pin_oe`=`core_oe[g]`.
- R3: Chain positions run from 0 (nearest `chain_tdo`) to LEN-1 (nearest `tdi`). Positions 0..N_IN-1 hold input pin i. Each output group g starts at base B=N_IN+g*(GRP_W+1): the control cell is at B, and data pin g*GRP_W+k is at B+1+k. `chain_tdo` always shows position 0.
- R4: On a rising edge with `shift_dr` high in modes 1 to 3, every position p takes the value of position p+1, and position LEN-1 takes `tdi`.
- R5: On a rising edge with `cap_dr` high and `shift_dr` low in modes 1 to 3, the chain loads its parallel inputs: `pin_in` into the input cells, `core_oe` into the control cells and `core_out` into the data cells.
- R6: In modes 0, 4, 5, 6 and 7 the chain ignores the capture and shift strobes and keeps its contents.
- R7: The update latches load the stage values on a falling edge while `upd_dr` is high in modes 1 to 3. At all other times they hold, so shifting never changes the pins.
- R8: In mode 1, the pins and `core_in` behave as in functional mode.
- R9: In mode 2, `pin_out` comes from the data-cell latches, each pin's `pin_oe` comes from its group's control latch, and `core_in` follows `pin_in`.
- R10: In mode 3, `core_in` comes from the input-cell latches, while `pin_out` and `pin_oe` behave as in functional mode.
- R11: In mode 4, `pin_out` and `pin_oe` come from the latches as in mode 2, while the chain stays frozen as R6 says.
- R12: In mode 5, every `pin_oe` bit is 0 whatever `core_oe` and the latches hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data into position LEN-1 |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe, acts on the falling edge |
| mode_sel | input | 3 | Decoded mode code |
| core_out | input | N_GRP*GRP_W | Core output data |
| core_oe | input | N_GRP | Core output enable for each group |
| pin_in | input | N_IN | Values on the input pins |
| pin_out | output | N_GRP*GRP_W | Data to the output pads |
| pin_oe | output | N_GRP*GRP_W | Enable for each output pad |
| core_in | output | N_IN | Data to the core inputs |
| chain_tdo | output | 1 | Serial output from position 0 |

## Verification
On every cycle, the assertions check the following:
- a shift moves the chain by one place, with `tdi` entering at the top;
- inactive modes freeze the chain;
- the update latches change only under an enabled update, and then copy the stages;
- high-impedance mode disables every output;
- external test and clamp route the latches to the pads, and internal test routes them to the core.

Some properties only the bench scenarios can show:
- that a preloaded pattern reaches the correct pins through the position map;
- that captured values come out of `chain_tdo` in position order;
- that a strobe ignored in clamp mode leaves the old contents in place for a later read.

// File: rtl/bsr_pkg.sv
// Shared mode encoding and helpers for the boundary scan register chain.
// Assumes the test controller supplies an already decoded 3-bit mode.
package bsr_pkg;

    typedef enum logic [2:0] {
        MODE_FUNC   = 3'd0,
        MODE_SAMPLE = 3'd1,
        MODE_EXT    = 3'd2,
        MODE_INT    = 3'd3,
        MODE_CLAMP  = 3'd4,
        MODE_HIGHZ  = 3'd5
    } bsr_mode_e;

    // True for the modes that route the serial path through the chain.
    function automatic logic chain_active(input logic [2:0] m);
        return (m == MODE_SAMPLE) || (m == MODE_EXT) || (m == MODE_INT);
    endfunction

    // True for the modes where the pads are driven from the update latches.
    function automatic logic pads_from_latch(input logic [2:0] m);
        return (m == MODE_EXT) || (m == MODE_CLAMP);
    endfunction

endpackage

// File: rtl/bsr_cell.sv
// One boundary cell: a capture/shift stage on the rising edge and an
// update latch that loads on the falling edge.
// Assumes shift and capture never both matter in one cycle; shift wins.
module bsr_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic par_in,
    input  logic ser_in,
    output logic stage_q,
    output logic upd_q
);

    // Capture/shift stage: serial move or parallel load on the rising edge.
    always_ff @(posedge tck) begin
        if (!rst_n)        stage_q <= 1'b0;
        else if (shift_en) stage_q <= ser_in;
        else if (cap_en)   stage_q <= par_in;
    end

    // Update latch: copies the stage on the falling edge when enabled.
    always_ff @(negedge tck) begin
        if (!rst_n)      upd_q <= 1'b0;
        else if (upd_en) upd_q <= stage_q;
    end

endmodule

// File: rtl/bsr_pin_mux.sv
// Pad and core-side selection between the functional path and the
// boundary latches, including forced high impedance.
// Assumes the latch vectors are already split by cell kind.
module bsr_pin_mux #(
    parameter int N_IN  = 4,
    parameter int N_GRP = 2,
    parameter int GRP_W = 2,
    localparam int N_OUT = N_GRP * GRP_W
) (
    input  logic [2:0]       mode_sel,
    input  logic [N_IN-1:0]  in_q,
    input  logic [N_OUT-1:0] dat_q,
    input  logic [N_GRP-1:0] ctl_q,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_GRP-1:0] core_oe,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe,
    output logic [N_IN-1:0]  core_in
);
    import bsr_pkg::*;

    logic use_latch;
    logic force_off;
    logic int_test;

    // Decode the mode into the three routing controls.
    always_comb begin
        use_latch = pads_from_latch(mode_sel);
        force_off = (mode_sel == MODE_HIGHZ);
        int_test  = (mode_sel == MODE_INT);
    end

    // Core inputs: from the input latches in internal test, else from pins.
    always_comb core_in = int_test ? in_q : pin_in;

    // Output data: from the data latches in external test and clamp.
    always_comb pin_out = use_latch ? dat_q : core_out;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar k = 0; k < GRP_W; k++) begin : g_pin
            // Output enable: gated by the group's control cell or the core.
            always_comb begin
                if (force_off)      pin_oe[g*GRP_W+k] = 1'b0;
                else if (use_latch) pin_oe[g*GRP_W+k] = ctl_q[g];
                else                pin_oe[g*GRP_W+k] = core_oe[g];
            end
        end
    end

endmodule

// File: rtl/bsr_chain.sv
// Boundary scan register chain: input cells, then for each output group
// one control cell followed by its data cells. Position 0 feeds chain_tdo.
// Assumes the strobes come from a test controller clocked by tck.
module bsr_chain #(
    parameter int N_IN  = 4,
    parameter int N_GRP = 2,
    parameter int GRP_W = 2,
    localparam int N_OUT = N_GRP * GRP_W,
    localparam int LEN   = N_IN + N_GRP * (GRP_W + 1)
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tdi,
    input  logic             cap_dr,
    input  logic             shift_dr,
    input  logic             upd_dr,
    input  logic [2:0]       mode_sel,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_GRP-1:0] core_oe,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe,
    output logic [N_IN-1:0]  core_in,
    output logic             chain_tdo
);
    import bsr_pkg::*;

    logic             active;
    logic [LEN-1:0]   par_vec;
    logic [LEN-1:0]   ser_vec;
    logic [LEN-1:0]   stage;
    logic [LEN-1:0]   upd_q;
    logic [N_IN-1:0]  in_q;
    logic [N_OUT-1:0] dat_q;
    logic [N_GRP-1:0] ctl_q;

    // Only the data-register modes route the serial path through the chain.
    always_comb active = chain_active(mode_sel);

    // Input cells capture the pins and occupy the lowest positions.
    always_comb par_vec[N_IN-1:0] = pin_in;
    always_comb in_q = upd_q[N_IN-1:0];

    for (genvar g = 0; g < N_GRP; g++) begin : g_map
        localparam int BASE = N_IN + g * (GRP_W + 1);
        // Control cell of the group captures the core enable.
        always_comb par_vec[BASE] = core_oe[g];
        always_comb ctl_q[g] = upd_q[BASE];
        for (genvar k = 0; k < GRP_W; k++) begin : g_dat
            // Data cell captures the core output headed to its pin.
            always_comb par_vec[BASE+1+k] = core_out[g*GRP_W+k];
            always_comb dat_q[g*GRP_W+k] = upd_q[BASE+1+k];
        end
    end

    for (genvar p = 0; p < LEN; p++) begin : g_cell
        // Serial source: tdi at the top, else the neighbour nearer tdi.
        if (p == LEN - 1) begin : g_top
            always_comb ser_vec[p] = tdi;
        end else begin : g_mid
            always_comb ser_vec[p] = stage[p+1];
        end

        bsr_cell u_cell (
            .tck      (tck),
            .rst_n    (rst_n),
            .cap_en   (cap_dr & active),
            .shift_en (shift_dr & active),
            .upd_en   (upd_dr & active),
            .par_in   (par_vec[p]),
            .ser_in   (ser_vec[p]),
            .stage_q  (stage[p]),
            .upd_q    (upd_q[p])
        );
    end

    // Serial output from the position nearest the output end.
    always_comb chain_tdo = stage[0];

    bsr_pin_mux #(
        .N_IN  (N_IN),
        .N_GRP (N_GRP),
        .GRP_W (GRP_W)
    ) u_mux (
        .mode_sel (mode_sel),
        .in_q     (in_q),
        .dat_q    (dat_q),
        .ctl_q    (ctl_q),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .core_in  (core_in)
    );

endmodule

// File: rtl/bsr_chain_chk.sv
// Property checker for bsr_chain, bound to every instance.
// Assumes inputs change only away from the rising edge of tck.
module bsr_chain_chk #(
    parameter int N_IN  = 4,
    parameter int N_GRP = 2,
    parameter int GRP_W = 2,
    localparam int N_OUT = N_GRP * GRP_W,
    localparam int LEN   = N_IN + N_GRP * (GRP_W + 1)
) (
    input logic             tck,
    input logic             rst_n,
    input logic             tdi,
    input logic             cap_dr,
    input logic             shift_dr,
    input logic             upd_dr,
    input logic [2:0]       mode_sel,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_OUT-1:0] pin_oe,
    input logic [N_IN-1:0]  core_in,
    input logic [LEN-1:0]   stage,
    input logic [LEN-1:0]   upd_q
);
    logic act;
    logic [N_OUT-1:0] exp_dat;
    logic [N_OUT-1:0] exp_oe;

    // Chain routing condition seen from the mode code.
    always_comb act = (mode_sel == 3'd1) || (mode_sel == 3'd2) || (mode_sel == 3'd3);

    // Latched pad values per pin, rebuilt from the position map.
    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            exp_dat[j] = upd_q[N_IN + (j / GRP_W) * (GRP_W + 1) + 1 + (j % GRP_W)];
            exp_oe[j]  = upd_q[N_IN + (j / GRP_W) * (GRP_W + 1)];
        end
    end

    p_shift_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_dr && act) |=> stage == {$past(tdi), $past(stage[LEN-1:1])});

    p_frozen_r6: assert property (@(posedge tck) disable iff (!rst_n)
        !act |=> $stable(stage));

    p_upd_load_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (upd_dr && act) |-> upd_q == stage);

    p_upd_hold_r7: assert property (@(posedge tck) disable iff (!rst_n)
        !(upd_dr && act) |-> upd_q == $past(upd_q));

    p_ext_pads_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (mode_sel == 3'd2) |-> (pin_out == exp_dat && pin_oe == exp_oe));

    p_int_core_r10: assert property (@(posedge tck) disable iff (!rst_n)
        (mode_sel == 3'd3) |-> core_in == upd_q[N_IN-1:0]);

    p_clamp_pads_r11: assert property (@(posedge tck) disable iff (!rst_n)
        (mode_sel == 3'd4) |-> (pin_out == exp_dat && pin_oe == exp_oe));

    p_highz_r12: assert property (@(posedge tck) disable iff (!rst_n)
        (mode_sel == 3'd5) |-> pin_oe == '0);

endmodule

bind bsr_chain bsr_chain_chk #(
    .N_IN  (N_IN),
    .N_GRP (N_GRP),
    .GRP_W (GRP_W)
) u_chk (
    .tck      (tck),
    .rst_n    (rst_n),
    .tdi      (tdi),
    .cap_dr   (cap_dr),
    .shift_dr (shift_dr),
    .upd_dr   (upd_dr),
    .mode_sel (mode_sel),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .core_in  (core_in),
    .stage    (stage),
    .upd_q    (upd_q)
);

// File: tb/test_bsr_chain.sv
// Self-checking bench for bsr_chain: a vector table followed by directed tests.
module test_bsr_chain;
    localparam int N_IN  = 4;
    localparam int N_GRP = 2;
    localparam int GRP_W = 2;
    localparam int N_OUT = N_GRP * GRP_W;
    localparam int LEN   = N_IN + N_GRP * (GRP_W + 1);

    typedef struct packed {
        logic [2:0]       mode;
        logic [LEN-1:0]   pat;
        logic [N_OUT-1:0] cout;
        logic [N_GRP-1:0] coe;
        logic [N_IN-1:0]  pin;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{3'd2, 10'b1011010110, 4'b0110, 2'b01, 4'b1001},
        '{3'd2, 10'b0110101001, 4'b1100, 2'b10, 4'b0110},
        '{3'd3, 10'b1100110011, 4'b1010, 2'b11, 4'b0101},
        '{3'd1, 10'b1111111111, 4'b0011, 2'b00, 4'b1110},
        '{3'd4, 10'b1001101010, 4'b0101, 2'b10, 4'b0011},
        '{3'd5, 10'b1111111111, 4'b1111, 2'b11, 4'b1010}
    };

    logic             tck = 1'b0;
    logic             rst_n = 1'b0;
    logic             tdi = 1'b0;
    logic             cap_dr = 1'b0;
    logic             shift_dr = 1'b0;
    logic             upd_dr = 1'b0;
    logic [2:0]       mode_sel = 3'd0;
    logic [N_OUT-1:0] core_out = '0;
    logic [N_GRP-1:0] core_oe = '0;
    logic [N_IN-1:0]  pin_in = '0;
    logic [N_OUT-1:0] pin_out;
    logic [N_OUT-1:0] pin_oe;
    logic [N_IN-1:0]  core_in;
    logic             chain_tdo;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 tck = ~tck;

    bsr_chain #(.N_IN(N_IN), .N_GRP(N_GRP), .GRP_W(GRP_W)) i_bsr_chain (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .mode_sel(mode_sel),
        .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in),
        .chain_tdo(chain_tdo)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    // Position map from R3: data pin and enable expected from a pattern.
    function automatic logic [N_OUT-1:0] map_dat(input logic [LEN-1:0] p);
        for (int j = 0; j < N_OUT; j++)
            map_dat[j] = p[N_IN + (j / GRP_W) * (GRP_W + 1) + 1 + (j % GRP_W)];
    endfunction

    function automatic logic [N_OUT-1:0] map_oe(input logic [LEN-1:0] p);
        for (int j = 0; j < N_OUT; j++)
            map_oe[j] = p[N_IN + (j / GRP_W) * (GRP_W + 1)];
    endfunction

    function automatic logic [N_OUT-1:0] func_oe(input logic [N_GRP-1:0] e);
        for (int j = 0; j < N_OUT; j++) func_oe[j] = e[j / GRP_W];
    endfunction

    function automatic logic [LEN-1:0] cap_image(input logic [N_OUT-1:0] co,
                                                 input logic [N_GRP-1:0] ce,
                                                 input logic [N_IN-1:0] pi);
        cap_image[N_IN-1:0] = pi;
        for (int g = 0; g < N_GRP; g++) begin
            cap_image[N_IN + g * (GRP_W + 1)] = ce[g];
            for (int k = 0; k < GRP_W; k++)
                cap_image[N_IN + g * (GRP_W + 1) + 1 + k] = co[g * GRP_W + k];
        end
    endfunction

    // Shift a pattern in so that pat[p] lands at position p, then update.
    task automatic preload(input logic [LEN-1:0] pat);
        shift_dr = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            tdi = pat[i];
            step();
        end
        shift_dr = 1'b0;
        upd_dr = 1'b1;
        step();
        upd_dr = 1'b0;
    endtask

    // Shift the chain out without capturing; bit i is position i.
    task automatic unload(output logic [LEN-1:0] got);
        shift_dr = 1'b1;
        tdi = 1'b0;
        for (int i = 0; i < LEN; i++) begin
            got[i] = chain_tdo;
            step();
        end
        shift_dr = 1'b0;
    endtask

    initial begin
        logic [LEN-1:0] got;
        vec_t v;
        step(); step(); step();
        // R1: reset state
        chk("R1 tdo", 16'(chain_tdo), 16'd0);
        rst_n = 1'b1;
        mode_sel = 3'd2;
        #1;
        chk("R1 pin_out", 16'(pin_out), 16'd0);
        chk("R1 pin_oe", 16'(pin_oe), 16'd0);
        step();

        for (int n = 0; n < NV; n++) begin
            v = VEC[n];
            core_out = v.cout; core_oe = v.coe; pin_in = v.pin;
            mode_sel = 3'd1;
            preload(v.pat);
            // R8: sample/preload keeps pins functional
            chk("R8 pin_out", 16'(pin_out), 16'(v.cout));
            chk("R8 core_in", 16'(core_in), 16'(v.pin));
            mode_sel = v.mode;
            #1;
            case (v.mode)
                3'd2: begin
                    chk("R9 pin_out", 16'(pin_out), 16'(map_dat(v.pat)));
                    chk("R9 pin_oe", 16'(pin_oe), 16'(map_oe(v.pat)));
                    chk("R9 core_in", 16'(core_in), 16'(v.pin));
                end
                3'd3: begin
                    chk("R10 core_in", 16'(core_in), 16'(v.pat[N_IN-1:0]));
                    chk("R10 pin_out", 16'(pin_out), 16'(v.cout));
                    chk("R10 pin_oe", 16'(pin_oe), 16'(func_oe(v.coe)));
                end
                3'd4: begin
                    chk("R11 pin_out", 16'(pin_out), 16'(map_dat(v.pat)));
                    chk("R11 pin_oe", 16'(pin_oe), 16'(map_oe(v.pat)));
                end
                3'd5: chk("R12 pin_oe", 16'(pin_oe), 16'd0);
                default: chk("R8 pin_oe", 16'(pin_oe), 16'(func_oe(v.coe)));
            endcase
            step();
            // R5 and R3: capture then read out in position order
            if (v.mode inside {3'd1, 3'd2, 3'd3}) begin
                cap_dr = 1'b1; step(); cap_dr = 1'b0;
                unload(got);
                chk("R5 capture", 16'(got), 16'(cap_image(v.cout, v.coe, v.pin)));
            end
        end

        // R4: a single shift brings position 1 to chain_tdo
        mode_sel = 3'd1;
        preload(10'b0000000010);
        chk("R4 before", 16'(chain_tdo), 16'd0);
        shift_dr = 1'b1; step(); shift_dr = 1'b0;
        chk("R4 after", 16'(chain_tdo), 16'd1);

        // R7: shifting in external test without update leaves pads alone
        mode_sel = 3'd1;
        preload(10'b1111111111);
        mode_sel = 3'd2;
        shift_dr = 1'b1; tdi = 1'b0;
        for (int i = 0; i < LEN; i++) step();
        shift_dr = 1'b0;
        chk("R7 hold", 16'(pin_out), 16'hF);

        // R6: clamp ignores strobes; the chain keeps the preloaded pattern
        mode_sel = 3'd1;
        preload(10'b1010011100);
        mode_sel = 3'd4;
        cap_dr = 1'b1; step(); cap_dr = 1'b0;
        shift_dr = 1'b1; tdi = 1'b1; step(); step(); shift_dr = 1'b0;
        mode_sel = 3'd1;
        unload(got);
        chk("R6 frozen", 16'(got), 16'(10'b1010011100));

        // R2: unused code 6 behaves as functional
        core_out = 4'b1001; core_oe = 2'b10; pin_in = 4'b0111;
        mode_sel = 3'd6;
        #1;
        chk("R2 pin_out", 16'(pin_out), 16'h9);
        chk("R2 pin_oe", 16'(pin_oe), 16'(4'b1100));
        chk("R2 core_in", 16'(core_in), 16'h7);
        step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule